// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the memory-side receiver of an asynchronous parallel flash bus, built entirely in synchronous logic on a fast system clock. The chip enable, output enable and write enable strobes, the address and the incoming data all pass through multi-flop synchronizers. Chip enable and write enable then go through a low-pulse filter, so that a strobe counts as asserted only after it has stayed low for a set number of clock samples. From these filtered strobes the block sorts every clock into one of five bus states: standby, read, write, output off and automatic standby.

For writes, the block takes the address at the moment the second of chip enable and write enable goes low. It takes the data from the last sample before the first of the two rises again. When the cycle closes it hands the pair to a command interpreter as a one-clock strobe. If output enable is seen low during the cycle, the block drops the cycle and raises a protocol-error pulse in its place.

For reads, the block asks an external array for a four-word page. It sends that request only when the upper address bits change. It drives the data bus, through a separate enable, from the returned read data once the array reports the data valid. If the address stays still during a read for long enough, the block reports automatic standby.

Top module: `flash_bus_front`

## Requirements
- R1: `bus_op` encodes the bus state as 0 standby, 1 read, 2 write, 3 output off, 4 automatic standby. The priority order is: chip enable not held low gives standby; otherwise write enable held low gives write; otherwise output enable high gives output off; otherwise read, or automatic standby when idle.
- R2: While chip enable is high, `bus_op` is standby and `bus_dq_oe` is 0, and no write strobe results, whatever output enable and write enable do.
- R3: A low pulse on chip enable or write enable that lasts fewer than `GLITCH_CLKS` consecutive clock samples has no effect on `bus_op` and produces no write. A pulse of exactly `GLITCH_CLKS` samples is accepted.
- R4: The write address is the address on the bus at the first sample where chip enable and write enable are both low. Later address changes in the same cycle are ignored.
- R5: The write data is the data on the bus at the last sample where chip enable and write enable were both still low. Data changes after either strobe rises are ignored.
- R6: `cmd_wr` pulses high for exactly one clock, the clock after `bus_op` leaves write. It carries `cmd_addr` and `cmd_data` from R4 and R5.
- R7: If output enable is low at any sampled clock of a write cycle, that cycle gives a one-clock `proto_err` pulse in place of `cmd_wr`.
- R8: While output enable is high, `bus_dq_oe` is 0 and `bus_dq_out` is 0.
- R9: During a read, `bus_dq_oe` rises only after `rd_valid` has been seen for the current page. While it is high, `bus_dq_out` equals `rd_data`. The bench's array returns address XOR 0x3C5A.
- R10: A read that starts, or a change of address bits above the two word-select bits during a read, pulses `page_req` and drops `bus_dq_oe` until `rd_valid` arrives. A change of only the two low bits requests nothing.
- R11: When a read has held the same address for more than `idle_limit` consecutive clocks, `bus_op` shows automatic standby. Any address change, or any control change that ends the read, returns it to read or another state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Bus chip enable, active low, asynchronous |
| out_en_n | input | 1 | Bus output enable, active low, asynchronous |
| wr_en_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_addr | input | AW | Bus address, asynchronous |
| bus_dq_in | input | DW | Data driven onto the bus by the host |
| idle_limit | input | IW | Idle clocks before automatic standby |
| rd_data | input | DW | Array word for `page_addr`/`word_sel` |
| rd_valid | input | 1 | Array reports the requested page ready |
| bus_dq_out | output | DW | Data driven to the bus during reads |
| bus_dq_oe | output | 1 | Tri-state enable for `bus_dq_out` |
| bus_op | output | 3 | Current bus state (encoding in R1) |
| page_req | output | 1 | One-clock request for a new page |
| page_addr | output | AW-2 | Page being read (upper address bits) |
| word_sel | output | 2 | Word within the page |
| cmd_wr | output | 1 | One-clock write strobe to the command interpreter |
| cmd_addr | output | AW | Captured write address |
| cmd_data | output | DW | Captured write data |
| proto_err | output | 1 | Write cycle discarded because output enable went low |

## Verification
The assertions check, on every clock, these invariants: the data bus is driven only in the read states; it stays off in standby and on the clock of a page request; the output-off state leaves the data lines at zero; a write strobe is a single clock that follows a write state two clocks back and never coincides with a protocol error; and automatic standby is entered only from a read. What only the bench scenarios can show is which address and data a write captures. The scenarios cover the write-enable-led and chip-enable-led orderings, and they show that pulses one sample short of the filter threshold are rejected while pulses at the threshold are accepted. They also show that word-only address changes issue no page request, and how many idle clocks lead to automatic standby. The bench reference model follows `bus_op` and the data-bus enable on every clock.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   typedef enum logic [2:0] {
      OP_STANDBY = 3'd0,
      OP_READ    = 3'd1,
      OP_WRITE   = 3'd2,
      OP_OUT_OFF = 3'd3,
      OP_AUTO_SB = 3'd4
   } bus_op_e;

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fbf_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fbf_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fbf_strobe_filter.sv
module fbf_strobe_filter #(
   parameter int MIN_LOW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic held_low
);

   generate
      if (MIN_LOW < 1) begin : g_bad_min
         $error("fbf_strobe_filter: MIN_LOW must be at least 1");
      end

      if (MIN_LOW == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_low <= 1'b0;
            else        held_low <= ~strobe_n;
         end
      end else begin : g_count
         localparam int             CW   = $clog2(MIN_LOW);
         localparam logic [CW-1:0]  LAST = CW'(MIN_LOW - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q    <= '0;
               held_low <= 1'b0;
            end else if (strobe_n) begin
               run_q    <= '0;
               held_low <= 1'b0;
            end else if (run_q == LAST) begin
               held_low <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fbf_write_capture.sv
module fbf_write_capture #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_ce_n,
   input  logic          s_we_n,
   input  logic          s_oe_n,
   input  logic [AW-1:0] s_addr,
   input  logic [DW-1:0] s_dq,
   input  logic          ce_held,
   input  logic          we_held,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          proto_err
);

   logic          in_write;
   logic          both_low;
   logic          armed_q;
   logic          active_q;
   logic          oe_bad_q;
   logic [AW-1:0] addr_hold_q;
   logic [DW-1:0] data_hold_q;

   assign in_write = ce_held & we_held;
   assign both_low = ~s_ce_n & ~s_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         active_q    <= 1'b0;
         oe_bad_q    <= 1'b0;
         addr_hold_q <= '0;
         data_hold_q <= '0;
         cmd_wr      <= 1'b0;
         cmd_addr    <= '0;
         cmd_data    <= '0;
         proto_err   <= 1'b0;
      end else begin
         cmd_wr    <= 1'b0;
         proto_err <= 1'b0;

         // address frozen at the later falling strobe, data tracked until the earlier rise
         if (both_low) begin
            data_hold_q <= s_dq;
            if (!armed_q) begin
               armed_q     <= 1'b1;
               addr_hold_q <= s_addr;
            end
         end else begin
            armed_q <= 1'b0;
         end

         if (active_q && !in_write) begin
            active_q <= 1'b0;
            oe_bad_q <= 1'b0;
            if (oe_bad_q || !s_oe_n) begin
               proto_err <= 1'b1;
            end else begin
               cmd_wr   <= 1'b1;
               cmd_addr <= addr_hold_q;
               cmd_data <= data_hold_q;
            end
         end else if (in_write) begin
            active_q <= 1'b1;
            if (!s_oe_n) oe_bad_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fbf_read_page.sv
module fbf_read_page #(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int WB = 2,
   parameter int IW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reading,
   input  logic [AW-1:0]    s_addr,
   input  logic [DW-1:0]    rd_data,
   input  logic             rd_valid,
   input  logic [IW-1:0]    idle_limit,
   output logic             page_req,
   output logic [AW-WB-1:0] page_addr,
   output logic [WB-1:0]    word_sel,
   output logic [DW-1:0]    dq_out,
   output logic             dq_oe,
   output logic             auto_sb
);

   localparam int TW = AW - WB;

   logic [TW-1:0] tag_q;
   logic          tag_ok_q;
   logic          pend_q;
   logic          page_ok_q;
   logic [TW-1:0] upper;
   logic          tag_hit;
   logic [AW-1:0] prev_addr_q;
   logic [IW-1:0] idle_cnt_q;

   assign upper   = s_addr[AW-1:WB];
   assign tag_hit = tag_ok_q && (upper == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q     <= '0;
         tag_ok_q  <= 1'b0;
         pend_q    <= 1'b0;
         page_ok_q <= 1'b0;
         page_req  <= 1'b0;
      end else begin
         page_req <= 1'b0;
         if (!reading) begin
            tag_ok_q  <= 1'b0;
            pend_q    <= 1'b0;
            page_ok_q <= 1'b0;
         end else if (!tag_hit) begin
            tag_q     <= upper;
            tag_ok_q  <= 1'b1;
            pend_q    <= 1'b1;
            page_ok_q <= 1'b0;
            page_req  <= 1'b1;
         end else if (pend_q && rd_valid) begin
            pend_q    <= 1'b0;
            page_ok_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_addr_q <= '0;
         idle_cnt_q  <= '0;
         auto_sb     <= 1'b0;
      end else begin
         prev_addr_q <= s_addr;
         if (reading && (s_addr == prev_addr_q)) begin
            if (idle_cnt_q >= idle_limit) auto_sb <= 1'b1;
            else                          idle_cnt_q <= idle_cnt_q + 1'b1;
         end else begin
            idle_cnt_q <= '0;
            auto_sb    <= 1'b0;
         end
      end
   end

   assign page_addr = tag_q;
   assign word_sel  = s_addr[WB-1:0];
   assign dq_oe     = reading & page_ok_q & tag_hit;
   assign dq_out    = dq_oe ? rd_data : '0;

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int PAGE_WORDS  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int GLITCH_CLKS = 3,
   parameter int IW          = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 chip_en_n,
   input  logic                                 out_en_n,
   input  logic                                 wr_en_n,
   input  logic [AW-1:0]                        bus_addr,
   input  logic [DW-1:0]                        bus_dq_in,
   input  logic [IW-1:0]                        idle_limit,
   input  logic [DW-1:0]                        rd_data,
   input  logic                                 rd_valid,
   output logic [DW-1:0]                        bus_dq_out,
   output logic                                 bus_dq_oe,
   output logic [2:0]                           bus_op,
   output logic                                 page_req,
   output logic [AW-$clog2(PAGE_WORDS)-1:0]     page_addr,
   output logic [$clog2(PAGE_WORDS)-1:0]        word_sel,
   output logic                                 cmd_wr,
   output logic [AW-1:0]                        cmd_addr,
   output logic [DW-1:0]                        cmd_data,
   output logic                                 proto_err
);

   import fbf_pkg::*;

   localparam int WB = $clog2(PAGE_WORDS);
   localparam int BW = AW + DW;

   generate
      if (PAGE_WORDS < 2 || (1 << WB) != PAGE_WORDS) begin : g_bad_page
         $error("flash_bus_front: PAGE_WORDS must be a power of two, at least 2");
      end
      if (AW <= WB) begin : g_bad_aw
         $error("flash_bus_front: AW must exceed the word-select width");
      end
      if (GLITCH_CLKS < 1) begin : g_bad_glitch
         $error("flash_bus_front: GLITCH_CLKS must be at least 1");
      end
      if (IW < 1) begin : g_bad_iw
         $error("flash_bus_front: IW must be at least 1");
      end
   endgenerate

   logic          s_ce_n, s_oe_n, s_we_n;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_dq;
   logic          ce_held, we_held;
   logic          reading;
   logic          auto_sb;
   bus_op_e       op;

   fbf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({chip_en_n, out_en_n, wr_en_n}),
      .q     ({s_ce_n, s_oe_n, s_we_n})
   );

   fbf_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL(BW'(0))) i_sync_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_addr, bus_dq_in}),
      .q     ({s_addr, s_dq})
   );

   fbf_strobe_filter #(.MIN_LOW(GLITCH_CLKS)) i_filt_ce (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (s_ce_n),
      .held_low (ce_held)
   );

   fbf_strobe_filter #(.MIN_LOW(GLITCH_CLKS)) i_filt_we (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (s_we_n),
      .held_low (we_held)
   );

   fbf_write_capture #(.AW(AW), .DW(DW)) i_wcap (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_ce_n    (s_ce_n),
      .s_we_n    (s_we_n),
      .s_oe_n    (s_oe_n),
      .s_addr    (s_addr),
      .s_dq      (s_dq),
      .ce_held   (ce_held),
      .we_held   (we_held),
      .cmd_wr    (cmd_wr),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .proto_err (proto_err)
   );

   assign reading = ce_held & ~we_held & ~s_oe_n;

   fbf_read_page #(.AW(AW), .DW(DW), .WB(WB), .IW(IW)) i_rpage (
      .clk        (clk),
      .rst_n      (rst_n),
      .reading    (reading),
      .s_addr     (s_addr),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .idle_limit (idle_limit),
      .page_req   (page_req),
      .page_addr  (page_addr),
      .word_sel   (word_sel),
      .dq_out     (bus_dq_out),
      .dq_oe      (bus_dq_oe),
      .auto_sb    (auto_sb)
   );

   always_comb begin
      if (!ce_held)      op = OP_STANDBY;
      else if (we_held)  op = OP_WRITE;
      else if (s_oe_n)   op = OP_OUT_OFF;
      else if (auto_sb)  op = OP_AUTO_SB;
      else               op = OP_READ;
   end

   assign bus_op = op;

endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    bus_op,
   input logic          bus_dq_oe,
   input logic [DW-1:0] bus_dq_out,
   input logic          cmd_wr,
   input logic          proto_err,
   input logic          page_req
);

   import fbf_pkg::*;

   // R9
   drive_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dq_oe |-> (bus_op == OP_READ || bus_op == OP_AUTO_SB));

   // R2
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == OP_STANDBY) |-> !bus_dq_oe);

   // R8
   out_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == OP_OUT_OFF) |-> (bus_dq_out == '0));

   // R6
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> !cmd_wr);

   // R6
   wr_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> ($past(bus_op, 2) == OP_WRITE));

   // R7
   err_excludes_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_wr && proto_err));

   // R10
   fetch_blanks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_req |-> !bus_dq_oe);

   // R11
   auto_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == OP_AUTO_SB) |-> ($past(bus_op) == OP_READ || $past(bus_op) == OP_AUTO_SB));

endmodule

bind flash_bus_front fbf_checker #(.DW(DW)) i_fbf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_op     (bus_op),
   .bus_dq_oe  (bus_dq_oe),
   .bus_dq_out (bus_dq_out),
   .cmd_wr     (cmd_wr),
   .proto_err  (proto_err),
   .page_req   (page_req)
);

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int GL = 3;
   localparam int IDLE = 20;
   localparam logic [15:0] MASK = 16'h3C5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0]   addr = '0, dq = '0;
   logic [7:0]    idle_limit = 8'(IDLE);
   logic [15:0]   rd_data;
   logic          rd_valid = 1'b0;
   logic [15:0]   dq_out;
   logic          dq_oe;
   logic [2:0]    bus_op;
   logic          page_req;
   logic [13:0]   page_addr;
   logic [1:0]    word_sel;
   logic          cmd_wr;
   logic [15:0]   cmd_addr, cmd_data;
   logic          proto_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_bus_front #(.AW(AW), .DW(DW), .GLITCH_CLKS(GL)) i_flash_bus_front (
      .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .out_en_n(oe_n), .wr_en_n(we_n),
      .bus_addr(addr), .bus_dq_in(dq), .idle_limit(idle_limit), .rd_data(rd_data),
      .rd_valid(rd_valid), .bus_dq_out(dq_out), .bus_dq_oe(dq_oe), .bus_op(bus_op),
      .page_req(page_req), .page_addr(page_addr), .word_sel(word_sel), .cmd_wr(cmd_wr),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .proto_err(proto_err)
   );

   // array model: word value is its address XOR MASK
   assign rd_data = {page_addr, word_sel} ^ MASK;

   int checks = 0, fails = 0;
   int wr_cnt = 0, err_cnt = 0, req_cnt = 0;
   logic [15:0] last_wa = '0, last_wd = '0;
   int lat = 0;
   bit done = 0;

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model (behavioural, per clock) ----------------
   bit          q1_ce, q1_oe, q1_we, m_ce, m_oe, m_we;
   logic [15:0] q1_a, m_a, m_prev;
   int          ce_run, we_run, idle_run;
   bit          fce, fwe, tv, pend, pok, m_auto;
   logic [13:0] tag;

   function automatic bit m_reading();
      return fce && !fwe && !m_oe;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q1_ce = 1; q1_oe = 1; q1_we = 1; m_ce = 1; m_oe = 1; m_we = 1;
         q1_a = '0; m_a = '0; m_prev = '0;
         ce_run = 0; we_run = 0; idle_run = 0;
         fce = 0; fwe = 0; tv = 0; pend = 0; pok = 0; m_auto = 0; tag = '0;
      end else begin
         bit rd;
         rd = m_reading();
         if (!rd) begin tv = 0; pend = 0; pok = 0; end
         else if (!tv || m_a[15:2] != tag) begin tag = m_a[15:2]; tv = 1; pend = 1; pok = 0; end
         else if (pend && rd_valid) begin pend = 0; pok = 1; end
         if (rd && m_a == m_prev) idle_run++; else idle_run = 0;
         m_auto = (idle_run > int'(idle_limit));
         m_prev = m_a;
         fce = (ce_run >= GL);
         fwe = (we_run >= GL);
         m_ce = q1_ce; m_oe = q1_oe; m_we = q1_we; m_a = q1_a;
         q1_ce = ce_n; q1_oe = oe_n; q1_we = we_n; q1_a = addr;
         ce_run = m_ce ? 0 : ce_run + 1;
         we_run = m_we ? 0 : we_run + 1;
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_op;
         bit exp_oe;
         if (!fce) exp_op = 0;
         else if (fwe) exp_op = 2;
         else if (m_oe) exp_op = 3;
         else if (m_auto) exp_op = 4;
         else exp_op = 1;
         exp_oe = m_reading() && pok && tv && (m_a[15:2] == tag);
         check("R1 bus_op", bus_op, exp_op);
         check("R9 dq_oe", dq_oe, exp_oe);
         check("R8 dq_out", dq_out, exp_oe ? (m_a ^ MASK) : 16'h0);
         if (cmd_wr) begin wr_cnt++; last_wa = cmd_addr; last_wd = cmd_data; end
         if (proto_err) err_cnt++;
         if (page_req) begin req_cnt++; lat = 4; rd_valid = 1'b0; end
         else if (lat > 0) begin lat--; rd_valid = (lat == 1); end
         else rd_valid = 1'b0;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pins(input bit c, input bit o, input bit w);
      ce_n = c; oe_n = o; we_n = w;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int w0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // reset state
      check("R1 reset op", bus_op, 0);
      check("R2 reset oe", dq_oe, 0);
      check("R6 reset wr", cmd_wr, 0);
      tick(4);

      // WE-led write; data changed after WE rises
      addr = 16'h1234; pins(0, 1, 1); tick(4);
      dq = 16'hBEEF; pins(0, 1, 0); tick(6);
      pins(0, 1, 1); dq = 16'h0F0F; tick(2);
      pins(1, 1, 1); tick(8);
      check("R6 we-led count", wr_cnt, 1);
      check("R4 we-led addr", last_wa, 16'h1234);
      check("R5 we-led data", last_wd, 16'hBEEF);

      // CE-led write; address set as CE falls, moved afterwards
      addr = 16'h0AAA; pins(1, 1, 0); tick(4);
      addr = 16'h4321; dq = 16'hC0DE; pins(0, 1, 0); tick(3);
      addr = 16'hFFFF; tick(4);
      pins(1, 1, 0); dq = 16'h5555; tick(2);
      pins(1, 1, 1); tick(8);
      check("R6 ce-led count", wr_cnt, 2);
      check("R4 ce-led addr", last_wa, 16'h4321);
      check("R5 ce-led data", last_wd, 16'hC0DE);

      // glitches one sample short of the threshold
      w0 = wr_cnt;
      addr = 16'h0100; pins(0, 1, 1); tick(5);
      pins(0, 1, 0); tick(GL - 1);
      pins(0, 1, 1); tick(8);
      check("R3 short we glitch", wr_cnt, w0);
      pins(1, 1, 0); tick(5);
      pins(0, 1, 0); tick(GL - 1);
      pins(1, 1, 0); tick(8);
      check("R3 short ce glitch", wr_cnt, w0);
      pins(1, 1, 1); tick(3);
      // pulse exactly at the threshold
      dq = 16'h7777; pins(0, 1, 1); tick(5);
      pins(0, 1, 0); tick(GL);
      pins(0, 1, 1); tick(8);
      check("R3 threshold pulse", wr_cnt, w0 + 1);
      check("R5 threshold data", last_wd, 16'h7777);
      pins(1, 1, 1); tick(4);

      // OE low inside a write
      w0 = wr_cnt;
      pins(0, 1, 0); tick(6);
      pins(0, 0, 0); tick(2);
      pins(0, 1, 0); tick(2);
      pins(1, 1, 1); tick(8);
      check("R7 error pulse", err_cnt, 1);
      check("R7 no strobe", wr_cnt, w0);

      // page reads
      w0 = req_cnt;
      addr = 16'h0120; pins(0, 0, 1); tick(14);
      check("R10 first fetch", req_cnt, w0 + 1);
      check("R9 drive on", dq_oe, 1);
      check("R9 data", dq_out, 16'h0120 ^ MASK);
      addr = 16'h0123; tick(4);
      check("R10 word change no fetch", req_cnt, w0 + 1);
      check("R9 word data", dq_out, 16'h0123 ^ MASK);
      addr = 16'h0240; tick(3);
      check("R10 new page blank", dq_oe, 0);
      tick(11);
      check("R10 new page fetch", req_cnt, w0 + 2);
      check("R9 new page data", dq_out, 16'h0240 ^ MASK);

      // output off
      pins(0, 1, 1); tick(4);
      check("R8 out off op", bus_op, 3);
      check("R8 out off oe", dq_oe, 0);
      pins(0, 0, 1); tick(14);
      check("R10 reread fetch", req_cnt, w0 + 3);

      // automatic standby
      tick(30);
      check("R11 auto entered", bus_op, 4);
      check("R11 auto drives", dq_oe, 1);
      addr = 16'h0241; tick(3);
      check("R11 auto left", bus_op, 1);

      // standby ignores OE and WE
      w0 = wr_cnt;
      pins(1, 0, 0); tick(8);
      check("R2 standby op", bus_op, 0);
      check("R2 standby oe", dq_oe, 0);
      pins(1, 1, 1); tick(8);
      check("R2 standby no write", wr_cnt, w0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule